// File: doc/BRIEF.md
# Configurable Clock Output Generator

This block drives one external clock pin from a set of on-chip clock sources. All of its settings sit in a single 32-bit control word at one address. Two paths feed the final selector. The first path divides the oscillator clock by a small integer. The second path picks one of six sources, divides it by an integer, and then divides that result by a power of two. The final selector chooses between the divided oscillator, the low-frequency RC clock, the second path and a dedicated external-device PLL output. A gate bit then enables or blocks the result.

Each source clock enters through a two-stage synchroniser clocked by the core clock `clk`. All division, selection and gating is then done as synchronous logic in that domain, and the output is a register, so it cannot glitch. Durations are whole `clk` cycles. A change to a selector or to the gate is held back until the outgoing and incoming levels are both low. A high pulse is therefore never cut short or created partway through.

Top module: `clkout_gen`

## Requirements
- R1: The control word is written when `reg_wr_i` is high and `reg_addr_i` equals the offset parameter (default 0x4100). Reads at that offset return the stored word, with every undefined bit reading 0. The defined-bit mask is 0x00B30777. Reads at any other address return 0, and writes there change nothing. The reset value is 0.
- R2: While the gate bit (bit 23) is 0, `clk_out_o` stays low.
- R3: The final select field, bits 17:16, chooses the output source: 0 is the oscillator path, 1 is the RC clock, 2 is the second path and 3 is the external-device PLL clock.
- R4: The oscillator divider field, bits 21:20, divides by the field value plus 1 (ratios 1 to 4). For a ratio N > 1 the output is high for floor(N/2) input periods and low for the rest. A ratio of 1 passes the input through unchanged.
- R5: The second-path select field, bits 2:0, picks the source in this order: 0 RC clock, 1 system-divider clock, 2 DDR PLL, 3 peripheral PLL, 4 display PLL, 5 MPU PLL. Codes 6 and 7 give a constant low.
- R6: The pre-divider field, bits 6:4, divides the second-path source by the field value plus 1 (ratios 1 to 8). It uses the same duty rule as R4.
- R7: The post-divider field, bits 10:8, divides the pre-divider output by 2 to the power of the field value. Field values above 5 divide by 32.
- R8: A change of final select, second-path select or gate takes effect only in a cycle where both the current and the requested level are low. No high pulse on `clk_out_o` is ever shorter than the shortest high phase of the sources involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 16 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| osc_clk_i | input | 1 | Oscillator clock |
| rc_clk_i | input | 1 | Low-frequency RC clock |
| sysdiv_clk_i | input | 1 | System clock divider output |
| ddr_pll_clk_i | input | 1 | DDR PLL output |
| per_pll_clk_i | input | 1 | Peripheral PLL output |
| disp_pll_clk_i | input | 1 | Display PLL output |
| mpu_pll_clk_i | input | 1 | MPU PLL output |
| extdev_pll_clk_i | input | 1 | External-device PLL output |
| clk_out_o | output | 1 | Gated output clock |

## Verification
A register write that changes the final select or the gate can land in the same cycle as a high phase of the selected clock. That is where the deferred switch has to hold the old setting. The bench provokes this by writing the RC and external-PLL selections, and gate off and on, at a sweep of cycle offsets while both clocks run. During that window it records every high run on `clk_out_o` and judges the result by requiring that no high run is shorter than the RC clock's high phase.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int CTRL_W       = 32;
  localparam int SRC2_SEL_LSB = 0;
  localparam int SRC2_SEL_W   = 3;
  localparam int PRE_LSB      = 4;
  localparam int PRE_W        = 3;
  localparam int POST_LSB     = 8;
  localparam int POST_W       = 3;
  localparam int FSEL_LSB     = 16;
  localparam int FSEL_W       = 2;
  localparam int OSC_LSB      = 20;
  localparam int OSC_W        = 2;
  localparam int GATE_BIT     = 23;

  localparam int N_SRC2       = 6;
  localparam int N_FINAL      = 4;
  localparam int N_SOURCES    = 8;
  localparam int POST_MAX_LOG = 5;

  localparam int OSC_MAX  = 1 << OSC_W;
  localparam int PRE_MAX  = 1 << PRE_W;
  localparam int POST_MAX = 1 << POST_MAX_LOG;

  localparam logic [CTRL_W-1:0] CTRL_MASK =
      (CTRL_W'((1 << SRC2_SEL_W) - 1) << SRC2_SEL_LSB) |
      (CTRL_W'((1 << PRE_W) - 1)      << PRE_LSB)      |
      (CTRL_W'((1 << POST_W) - 1)     << POST_LSB)     |
      (CTRL_W'((1 << FSEL_W) - 1)     << FSEL_LSB)     |
      (CTRL_W'((1 << OSC_W) - 1)      << OSC_LSB)      |
      (CTRL_W'(1)                     << GATE_BIT);

  // Index of each synchronised source in the internal source vector
  typedef enum int {
    SRC_OSC    = 0,
    SRC_RC     = 1,
    SRC_SYSDIV = 2,
    SRC_DDR    = 3,
    SRC_PER    = 4,
    SRC_DISP   = 5,
    SRC_MPU    = 6,
    SRC_EXTDEV = 7
  } src_idx_e;
endpackage

// File: rtl/clkout_rst_sync.sv
module clkout_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/clkout_src_sync.sv
module clkout_src_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              dly_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], src_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      dly_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      dly_q  <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~dly_q;
endmodule

// File: rtl/clkout_div.sv
module clkout_div #(
  parameter int MAX_RATIO = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [$clog2(MAX_RATIO+1)-1:0]     ratio_i,
  input  logic                               lvl_i,
  input  logic                               rise_i,
  output logic                               lvl_o,
  output logic                               rise_o
);
  localparam int RW = $clog2(MAX_RATIO + 1);
  localparam int CW = (MAX_RATIO > 1) ? $clog2(MAX_RATIO) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          rise_q, rise_d;
  logic          cnt_en;
  logic [RW:0]   cnt_inc;
  logic [RW:0]   cnt_nxt;
  logic [RW:0]   half;
  logic          wrap;
  logic          bypass;

  assign bypass  = (ratio_i <= RW'(1));
  assign cnt_en  = rise_i;
  assign cnt_inc = (RW+1)'(cnt_q) + (RW+1)'(1);
  assign wrap    = (cnt_inc >= {1'b0, ratio_i});
  assign cnt_nxt = wrap ? '0 : cnt_inc;
  assign half    = {1'b0, ratio_i} >> 1;

  always_comb begin
    cnt_d  = CW'(cnt_nxt);
    lvl_d  = (cnt_nxt < half);
    rise_d = cnt_en & lvl_d & ~lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      rise_q <= rise_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
        lvl_q <= lvl_d;
      end
    end
  end

  assign lvl_o  = bypass ? lvl_i  : lvl_q;
  assign rise_o = bypass ? rise_i : rise_q;

  // Registered level moves only on an input rising edge
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_i |=> $stable(lvl_q)); // R4
endmodule

// File: rtl/clkout_mux.sv
module clkout_mux #(
  parameter int N_IN  = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_req_i,
  input  logic [N_IN-1:0]  lvl_i,
  input  logic [N_IN-1:0]  rise_i,
  output logic             lvl_o,
  output logic             rise_o
);
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             sel_en;
  logic             cur_lvl, cur_rise, cand_lvl;

  always_comb begin
    cur_lvl  = 1'b0;
    cur_rise = 1'b0;
    cand_lvl = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (sel_q == SEL_W'(i)) begin
        cur_lvl  = lvl_i[i];
        cur_rise = rise_i[i];
      end
      if (sel_req_i == SEL_W'(i)) cand_lvl = lvl_i[i];
    end
  end

  assign sel_en = (sel_req_i != sel_q) && !cur_lvl && !cand_lvl;

  always_comb begin
    sel_d = sel_en ? sel_req_i : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign lvl_o  = cur_lvl;
  assign rise_o = cur_rise;

  AST_SEL_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> !$past(lvl_o)); // R8
  AST_RSV_SEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sel_q) >= N_IN) |-> !lvl_o); // R5
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen #(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 'h4100,
  parameter int                SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] reg_addr_i,
  input  logic        reg_wr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        osc_clk_i,
  input  logic        rc_clk_i,
  input  logic        sysdiv_clk_i,
  input  logic        ddr_pll_clk_i,
  input  logic        per_pll_clk_i,
  input  logic        disp_pll_clk_i,
  input  logic        mpu_pll_clk_i,
  input  logic        extdev_pll_clk_i,
  output logic        clk_out_o
);
  import clkout_pkg::*;

  localparam int OSC_RW  = $clog2(OSC_MAX + 1);
  localparam int PRE_RW  = $clog2(PRE_MAX + 1);
  localparam int POST_RW = $clog2(POST_MAX + 1);

  logic rst_sync_n;

  clkout_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Control register
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              addr_hit;
  logic              ctrl_en;

  assign addr_hit = (reg_addr_i[ADDR_W-1:0] == CTRL_OFFSET);
  assign ctrl_en  = reg_wr_i & addr_hit;

  always_comb begin
    ctrl_d = ctrl_en ? (reg_wdata_i & CTRL_MASK) : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctrl_q <= '0;
    else             ctrl_q <= ctrl_d;
  end

  assign reg_rdata_o = addr_hit ? ctrl_q : '0;

  // Field decode
  logic [SRC2_SEL_W-1:0] src2_sel;
  logic [FSEL_W-1:0]     fsel;
  logic                  gate_req;
  logic [OSC_RW-1:0]     osc_ratio;
  logic [PRE_RW-1:0]     pre_ratio;
  logic [POST_RW-1:0]    post_ratio;
  logic [POST_W-1:0]     post_field;

  assign src2_sel   = ctrl_q[SRC2_SEL_LSB +: SRC2_SEL_W];
  assign fsel       = ctrl_q[FSEL_LSB +: FSEL_W];
  assign gate_req   = ctrl_q[GATE_BIT];
  assign osc_ratio  = OSC_RW'(ctrl_q[OSC_LSB +: OSC_W]) + OSC_RW'(1);
  assign pre_ratio  = PRE_RW'(ctrl_q[PRE_LSB +: PRE_W]) + PRE_RW'(1);
  assign post_field = ctrl_q[POST_LSB +: POST_W];
  assign post_ratio = (32'(post_field) > POST_MAX_LOG) ? POST_RW'(POST_MAX)
                                                      : (POST_RW'(1) << post_field);

  // Source synchronisers
  logic [N_SOURCES-1:0] src_raw;
  logic [N_SOURCES-1:0] src_lvl;
  logic [N_SOURCES-1:0] src_rise;

  assign src_raw[SRC_OSC]    = osc_clk_i;
  assign src_raw[SRC_RC]     = rc_clk_i;
  assign src_raw[SRC_SYSDIV] = sysdiv_clk_i;
  assign src_raw[SRC_DDR]    = ddr_pll_clk_i;
  assign src_raw[SRC_PER]    = per_pll_clk_i;
  assign src_raw[SRC_DISP]   = disp_pll_clk_i;
  assign src_raw[SRC_MPU]    = mpu_pll_clk_i;
  assign src_raw[SRC_EXTDEV] = extdev_pll_clk_i;

  for (genvar g = 0; g < N_SOURCES; g++) begin : g_sync
    clkout_src_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .src_i  (src_raw[g]),
      .lvl_o  (src_lvl[g]),
      .rise_o (src_rise[g])
    );
  end

  // Path A: oscillator divider
  logic osc_div_lvl, osc_div_rise;

  clkout_div #(.MAX_RATIO(OSC_MAX)) u_osc_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ratio_i (osc_ratio),
    .lvl_i   (src_lvl[SRC_OSC]),
    .rise_i  (src_rise[SRC_OSC]),
    .lvl_o   (osc_div_lvl),
    .rise_o  (osc_div_rise)
  );

  // Path B: six-way select, pre-divider, power-of-two post-divider
  logic src2_lvl, src2_rise;
  logic pre_lvl, pre_rise;
  logic post_lvl, post_rise;

  clkout_mux #(.N_IN(N_SRC2), .SEL_W(SRC2_SEL_W)) u_src2_mux (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel_req_i (src2_sel),
    .lvl_i     (src_lvl[SRC_MPU:SRC_RC]),
    .rise_i    (src_rise[SRC_MPU:SRC_RC]),
    .lvl_o     (src2_lvl),
    .rise_o    (src2_rise)
  );

  clkout_div #(.MAX_RATIO(PRE_MAX)) u_pre_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ratio_i (pre_ratio),
    .lvl_i   (src2_lvl),
    .rise_i  (src2_rise),
    .lvl_o   (pre_lvl),
    .rise_o  (pre_rise)
  );

  clkout_div #(.MAX_RATIO(POST_MAX)) u_post_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ratio_i (post_ratio),
    .lvl_i   (pre_lvl),
    .rise_i  (pre_rise),
    .lvl_o   (post_lvl),
    .rise_o  (post_rise)
  );

  // Final selector
  logic [N_FINAL-1:0] fin_lvl, fin_rise;
  logic               fmux_lvl, fmux_rise;

  assign fin_lvl  = {src_lvl[SRC_EXTDEV],  post_lvl,  src_lvl[SRC_RC],  osc_div_lvl};
  assign fin_rise = {src_rise[SRC_EXTDEV], post_rise, src_rise[SRC_RC], osc_div_rise};

  clkout_mux #(.N_IN(N_FINAL), .SEL_W(FSEL_W)) u_final_mux (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel_req_i (fsel),
    .lvl_i     (fin_lvl),
    .rise_i    (fin_rise),
    .lvl_o     (fmux_lvl),
    .rise_o    (fmux_rise)
  );

  // Gate, applied only while the selected level is low
  logic gate_q, gate_d, gate_en;
  logic out_q, out_d;

  assign gate_en = !fmux_lvl;

  always_comb begin
    gate_d = gate_en ? gate_req : gate_q;
    out_d  = gate_q & fmux_lvl;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      gate_q <= gate_d;
      out_q  <= out_d;
    end
  end

  assign clk_out_o = out_q;

  AST_GATE_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !gate_q |=> !clk_out_o); // R2
  AST_GATE_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(gate_q) |-> !$past(fmux_lvl)); // R8
  AST_RD_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_rdata_o & ~CTRL_MASK) == '0); // R1
  AST_OUT_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(clk_out_o) |-> $past(fmux_lvl) && $past(gate_q)); // R2
endmodule

// File: tb/clkout_gen_tb_top.sv
module clkout_gen_tb_top;
  localparam logic [15:0] OFF  = 16'h4100;
  localparam logic [31:0] GATE = 32'h0080_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reg_addr = OFF;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic osc_c = 0, rc_c = 0, sd_c = 0, ddr_c = 0, per_c = 0, disp_c = 0, mpu_c = 0, ext_c = 0;
  logic clk_out;

  int n_checks = 0;
  int n_errors = 0;

  typedef struct { int hi; int lo; string req; } exp_t;
  exp_t exp_q[$];

  logic mon_restart = 1'b0;
  int   mstate = 0;
  int   hcnt = 0;
  int   lcnt = 0;
  logic prev_out = 1'b0;

  logic trk_on = 1'b0;
  logic trk_first = 1'b0;
  int   trk_run = 0;
  int   trk_min_hi = 1000000;

  always #5 clk = ~clk;

  // Source clocks: half periods in clock cycles, edges away from clk edges
  initial begin #3; forever begin #20 osc_c  = ~osc_c;  end end // period 4
  initial begin #3; forever begin #30 rc_c   = ~rc_c;   end end // period 6
  initial begin #3; forever begin #40 sd_c   = ~sd_c;   end end // period 8
  initial begin #3; forever begin #50 ddr_c  = ~ddr_c;  end end // period 10
  initial begin #3; forever begin #60 per_c  = ~per_c;  end end // period 12
  initial begin #3; forever begin #70 disp_c = ~disp_c; end end // period 14
  initial begin #3; forever begin #80 mpu_c  = ~mpu_c;  end end // period 16
  initial begin #3; forever begin #90 ext_c  = ~ext_c;  end end // period 18

  clkout_gen dut_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .reg_addr_i       (reg_addr),
    .reg_wr_i         (reg_wr),
    .reg_wdata_i      (reg_wdata),
    .reg_rdata_o      (reg_rdata),
    .osc_clk_i        (osc_c),
    .rc_clk_i         (rc_c),
    .sysdiv_clk_i     (sd_c),
    .ddr_pll_clk_i    (ddr_c),
    .per_pll_clk_i    (per_c),
    .disp_pll_clk_i   (disp_c),
    .mpu_pll_clk_i    (mpu_c),
    .extdev_pll_clk_i (ext_c),
    .clk_out_o        (clk_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  task automatic write_reg(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
    reg_addr  = OFF;
  endtask

  task automatic read_reg(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = OFF;
  endtask

  // Scoreboard driver: configure, let it settle, queue the expected pulse
  task automatic run_case(input logic [31:0] cfg, input int hi, input int lo, input string req);
    exp_t e;
    int   guard;
    write_reg(OFF, cfg);
    repeat (4 * (hi + lo) + 80) @(negedge clk);
    mon_restart = 1'b1;
    e.hi = hi; e.lo = lo; e.req = req;
    exp_q.push_back(e);
    guard = 0;
    while (exp_q.size() != 0 && guard < 4 * (hi + lo) + 100) begin
      @(negedge clk);
      guard++;
    end
    if (exp_q.size() != 0) begin
      n_checks++;
      n_errors++;
      $display("FAIL %s no full pulse seen, expected high=%0d low=%0d", req, hi, lo);
      exp_q.delete();
    end
  endtask

  task automatic expect_low(input logic [31:0] cfg, input string req);
    int highs;
    write_reg(OFF, cfg);
    repeat (150) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (clk_out) highs++;
    end
    check(req, highs, 0);
  endtask

  // Scoreboard monitor: measure each high run and the low run after it
  always @(negedge clk) begin
    exp_t e;
    if (mon_restart) begin
      mstate      = 0;
      mon_restart = 1'b0;
    end else begin
      case (mstate)
        0: if (clk_out && !prev_out) begin mstate = 1; hcnt = 1; end
        1: if (clk_out) hcnt++; else begin mstate = 2; lcnt = 1; end
        default: if (!clk_out) lcnt++;
                 else begin
                   if (exp_q.size() > 0) begin
                     e = exp_q.pop_front();
                     n_checks++;
                     if (hcnt != e.hi || lcnt != e.lo) begin
                       n_errors++;
                       $display("FAIL %s actual high=%0d low=%0d expected high=%0d low=%0d",
                                e.req, hcnt, lcnt, e.hi, e.lo);
                     end
                   end
                   mstate = 1;
                   hcnt   = 1;
                 end
      endcase
    end
    // High-run tracker for the switching window; first run is partial
    if (trk_on) begin
      if (clk_out != prev_out) begin
        if (!trk_first && prev_out && trk_run < trk_min_hi) trk_min_hi = trk_run;
        trk_first = 1'b0;
        trk_run   = 1;
      end else begin
        trk_run++;
      end
    end
    prev_out = clk_out;
  end

  initial begin
    #(200000 * 10);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] rd;
    #52 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state and R2 output low after reset
    read_reg(OFF, rd);
    check("R1 reset value", rd, 32'h0);
    check("R2 output low after reset", {31'b0, clk_out}, 32'h0);

    // R1 mask, foreign address
    write_reg(OFF, 32'hFFFF_FFFF);
    read_reg(OFF, rd);
    check("R1 defined bits only", rd, 32'h00B3_0777);
    read_reg(16'h4104, rd);
    check("R1 other address reads 0", rd, 32'h0);
    write_reg(16'h4104, 32'h0000_0000);
    read_reg(OFF, rd);
    check("R1 other address write ignored", rd, 32'h00B3_0777);

    // R2 gate off
    expect_low(32'h0000_0000 | (32'd1 << 16), "R2 gate off holds low");

    // R3 / R4 oscillator path (period 4)
    run_case(GATE | (32'd0 << 20), 2, 2, "R3 R4 osc ratio 1");
    run_case(GATE | (32'd1 << 20), 4, 4, "R4 osc ratio 2");
    run_case(GATE | (32'd2 << 20), 4, 8, "R4 osc ratio 3 odd");
    run_case(GATE | (32'd3 << 20), 8, 8, "R4 osc ratio 4");

    // R3 other final inputs
    run_case(GATE | (32'd1 << 16), 3, 3, "R3 final sel RC");
    run_case(GATE | (32'd3 << 16), 9, 9, "R3 final sel extdev PLL");

    // R5 second-path source order
    for (int s = 0; s < 6; s++) begin
      run_case(GATE | (32'd2 << 16) | 32'(s), 3 + s, 3 + s, $sformatf("R5 src2 sel %0d", s));
    end
    expect_low(GATE | (32'd2 << 16) | 32'd6, "R5 reserved sel 6 low");
    expect_low(GATE | (32'd2 << 16) | 32'd7, "R5 reserved sel 7 low");

    // R6 pre-divider
    run_case(GATE | (32'd2 << 16) | (32'd2 << 4) | 32'd1, 8, 16, "R6 pre ratio 3 on sysdiv");
    run_case(GATE | (32'd2 << 16) | (32'd7 << 4) | 32'd0, 24, 24, "R6 pre ratio 8 on RC");

    // R7 post-divider
    run_case(GATE | (32'd2 << 16) | (32'd2 << 8) | 32'd2, 20, 20, "R7 post ratio 4 on DDR");
    run_case(GATE | (32'd2 << 16) | (32'd1 << 8) | (32'd2 << 4), 18, 18, "R6 R7 pre 3 then post 2");
    run_case(GATE | (32'd2 << 16) | (32'd7 << 8), 96, 96, "R7 post field 7 clamps to 32");

    // R8 writes landing at every phase of the running clocks
    write_reg(OFF, GATE | (32'd1 << 16));
    repeat (60) @(negedge clk);
    trk_first  = 1'b1;
    trk_min_hi = 1000000;
    trk_on     = 1'b1;
    for (int k = 0; k < 9; k++) begin
      repeat (k) @(negedge clk);
      write_reg(OFF, GATE | (32'd3 << 16));
      repeat (40 + k) @(negedge clk);
      write_reg(OFF, GATE | (32'd1 << 16));
      repeat (31 + k) @(negedge clk);
      write_reg(OFF, 32'd1 << 16);
      repeat (20 + k) @(negedge clk);
      write_reg(OFF, GATE | (32'd1 << 16));
      repeat (25) @(negedge clk);
    end
    trk_on = 1'b0;
    n_checks++;
    if (trk_min_hi < 3) begin
      n_errors++;
      $display("FAIL R8 shortest high run actual=%0d expected>=3", trk_min_hi);
    end

    summary();
  end
endmodule